// File: doc/BRIEF.md
# Internal Data Space Decoder

This block fronts the 8-bit internal data space of a small accumulator-style core. Each access carries an 8-bit address, a flag that says whether the address came from the instruction itself (direct) or from a pointer register (indirect), and a read strobe, a write strobe or both. The lower half of the space (0x00 to 0x7F) is one RAM that both modes reach. The upper half (0x80 to 0xFF) has two meanings. A direct access there goes out on a separate port to the peripheral registers. An indirect access there reaches extra RAM, but only in the build that has that RAM.

The parameter `UPPER_RAM` picks the variant. With 1, the block holds 256 bytes. With 0, it holds 128 bytes, and an indirect access above 0x7F hits nothing and is flagged as an error. Reads are synchronous and always complete one cycle after the strobe, whichever target they hit.

The block takes every strobe in the cycle it is raised. It has no back-pressure and no handshake: the core owns the timing, and `rd_valid` only marks the cycle in which read data appears.

Top module: `idata_space_decoder`

## Requirements
- R1: Addresses 0x00 to 0x7F are one shared RAM. A byte written with either mode reads back unchanged with the other mode.
- R2: `rd_valid` is high in exactly the cycle after a cycle with `acc_rd` high, and `rd_data` holds the read result in that cycle.
- R3: A direct access (`acc_indirect`=0) with an address of 0x80 or above raises `sfr_sel` in the same cycle. In that cycle `sfr_addr` equals the address, `sfr_wdata` equals the write data, and `sfr_wr` is high if and only if `acc_wr` is high.
- R4: For a direct read at 0x80 or above, `rd_data` in the next cycle equals the `sfr_rdata` value present in the strobe cycle.
- R5: `sfr_sel` and `sfr_wr` stay low for every indirect access and for every address below 0x80.
- R6: With `UPPER_RAM`=1, indirect accesses at 0x80 to 0xFF read and write a RAM byte that is separate from address minus 0x80, and they do not raise `bad_access`.
- R7: With `UPPER_RAM`=0, an indirect read at 0x80 to 0xFF returns 0xFF and raises `bad_access` in the next cycle.
- R8: With `UPPER_RAM`=0, an indirect write at 0x80 to 0xFF changes no RAM byte (in particular not address minus 0x80), leaves `sfr_sel` low and raises `bad_access` in the next cycle.
- R9: After reset, `rd_valid` and `bad_access` are low.
- R10: A read and a write to the same RAM byte in one cycle return the byte's old value, and the new value is stored.
- R11: A direct write at 0x80 or above leaves the upper RAM byte at the same address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_rd | input | 1 | Read strobe |
| acc_wr | input | 1 | Write strobe |
| acc_indirect | input | 1 | 1 = indirect (pointer) access, 0 = direct access |
| acc_addr | input | 8 | Internal data address |
| acc_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read result, valid one cycle after `acc_rd` |
| rd_valid | output | 1 | Marks the cycle that carries read data |
| bad_access | output | 1 | One-cycle flag for an indirect access to missing upper RAM |
| sfr_sel | output | 1 | Peripheral register access in this cycle |
| sfr_wr | output | 1 | The peripheral access is a write |
| sfr_addr | output | 8 | Peripheral register address |
| sfr_wdata | output | 8 | Peripheral register write data |
| sfr_rdata | input | 8 | Peripheral register read data for `sfr_addr`, same cycle |

## Verification
The bench builds two copies side by side on the same stimulus: one with `UPPER_RAM`=1 and one with `UPPER_RAM`=0. Both see the same address and mode. The 256-byte copy shows indirect upper addresses landing in separate RAM that direct writes cannot disturb. The 128-byte copy shows the same accesses returning 0xFF, raising the error flag and leaving the aliased lower byte intact.

// File: rtl/idsd_pkg.sv
package idsd_pkg;
  typedef enum logic [1:0] {
    TGT_LOW_RAM  = 2'd0,
    TGT_HIGH_RAM = 2'd1,
    TGT_SFR      = 2'd2,
    TGT_NONE     = 2'd3
  } target_e;
endpackage

// File: rtl/idsd_decode.sv
module idsd_decode
  import idsd_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter bit UPPER_RAM = 1'b1
) (
  input  logic              indirect,
  input  logic [ADDR_W-1:0] addr,
  output target_e           tgt
);
  // The top address bit splits the space in half; the mode only matters above it.
  always_comb begin
    if (!addr[ADDR_W-1])   tgt = TGT_LOW_RAM;
    else if (!indirect)    tgt = TGT_SFR;
    else if (UPPER_RAM)    tgt = TGT_HIGH_RAM;
    else                   tgt = TGT_NONE;
  end
endmodule

// File: rtl/idsd_ram.sv
module idsd_ram #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              re,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] mem [DEPTH];

  // Read-before-write: a same-cycle read sees the old byte.
  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    if (re) q <= mem[idx];
  end
endmodule

// File: rtl/idsd_rdstage.sv
module idsd_rdstage
  import idsd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic              wr,
  input  target_e           tgt,
  input  logic [DATA_W-1:0] sfr_rdata,
  input  logic [DATA_W-1:0] ram_q,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              bad_access
);
  target_e           src_q;
  logic [DATA_W-1:0] sfr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid   <= 1'b0;
      bad_access <= 1'b0;
      src_q      <= TGT_NONE;
      sfr_q      <= '0;
    end else begin
      rd_valid   <= rd;
      bad_access <= (rd || wr) && (tgt == TGT_NONE);
      if (rd) begin
        src_q <= tgt;
        sfr_q <= sfr_rdata;
      end
    end
  end

  always_comb begin
    case (src_q)
      TGT_LOW_RAM, TGT_HIGH_RAM: rd_data = ram_q;
      TGT_SFR:                   rd_data = sfr_q;
      default:                   rd_data = '1;
    endcase
  end
endmodule

// File: rtl/idata_space_decoder.sv
module idata_space_decoder
  import idsd_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter bit UPPER_RAM = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  logic              acc_indirect,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              bad_access,
  output logic              sfr_sel,
  output logic              sfr_wr,
  output logic [ADDR_W-1:0] sfr_addr,
  output logic [DATA_W-1:0] sfr_wdata,
  input  logic [DATA_W-1:0] sfr_rdata
);
  localparam int FULL_DEPTH = 1 << ADDR_W;
  localparam int RAM_DEPTH  = UPPER_RAM ? FULL_DEPTH : FULL_DEPTH / 2;
  localparam int IDX_W      = $clog2(RAM_DEPTH);

  target_e           tgt;
  logic              ram_hit;
  logic [DATA_W-1:0] ram_q;

  idsd_decode #(.ADDR_W(ADDR_W), .UPPER_RAM(UPPER_RAM)) u_decode (
    .indirect (acc_indirect),
    .addr     (acc_addr),
    .tgt      (tgt)
  );

  assign ram_hit = (tgt == TGT_LOW_RAM) || (tgt == TGT_HIGH_RAM);

  idsd_ram #(.DEPTH(RAM_DEPTH), .DATA_W(DATA_W)) u_ram (
    .clk   (clk),
    .re    (acc_rd && ram_hit),
    .we    (acc_wr && ram_hit),
    .idx   (acc_addr[IDX_W-1:0]),
    .wdata (acc_wdata),
    .q     (ram_q)
  );

  assign sfr_sel   = (acc_rd || acc_wr) && (tgt == TGT_SFR);
  assign sfr_wr    = acc_wr && (tgt == TGT_SFR);
  assign sfr_addr  = acc_addr;
  assign sfr_wdata = acc_wdata;

  idsd_rdstage #(.DATA_W(DATA_W)) u_rdstage (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd         (acc_rd),
    .wr         (acc_wr),
    .tgt        (tgt),
    .sfr_rdata  (sfr_rdata),
    .ram_q      (ram_q),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid),
    .bad_access (bad_access)
  );
endmodule

// File: rtl/idsd_checker.sv
module idsd_checker #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter bit UPPER_RAM = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_rd,
  input logic              acc_wr,
  input logic              acc_indirect,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid,
  input logic              bad_access,
  input logic              sfr_sel,
  input logic              sfr_wr
);
  // R2
  rd_valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |=> rd_valid);

  // R2
  rd_valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_rd |=> !rd_valid);

  // R3
  sfr_direct_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((acc_rd || acc_wr) && !acc_indirect && acc_addr[ADDR_W-1]) |-> sfr_sel);

  // R5
  sfr_sel_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_sel |-> (!acc_indirect && acc_addr[ADDR_W-1]));

  // R5
  sfr_wr_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_wr |-> (sfr_sel && acc_wr));

  generate
    if (UPPER_RAM) begin : g_full
      // R6
      no_bad_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd || acc_wr) |=> !bad_access);
    end else begin : g_half
      // R7
      hole_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && acc_indirect && acc_addr[ADDR_W-1]) |=> (bad_access && rd_data == '1));
      // R8
      hole_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && acc_indirect && acc_addr[ADDR_W-1]) |=> bad_access);
    end
  endgenerate
endmodule

bind idata_space_decoder idsd_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .UPPER_RAM(UPPER_RAM)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .acc_rd       (acc_rd),
  .acc_wr       (acc_wr),
  .acc_indirect (acc_indirect),
  .acc_addr     (acc_addr),
  .rd_data      (rd_data),
  .rd_valid     (rd_valid),
  .bad_access   (bad_access),
  .sfr_sel      (sfr_sel),
  .sfr_wr       (sfr_wr)
);

// File: tb/idata_space_decoder_test.sv
module idata_space_decoder_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_rd = 1'b0, acc_wr = 1'b0, acc_indirect = 1'b0;
  logic [7:0] acc_addr = '0, acc_wdata = '0;

  logic [7:0] f_rd_data, f_sfr_addr, f_sfr_wdata, f_sfr_rdata;
  logic       f_rd_valid, f_bad, f_sel, f_sfr_wr;
  logic [7:0] h_rd_data, h_sfr_addr, h_sfr_wdata, h_sfr_rdata;
  logic       h_rd_valid, h_bad, h_sel, h_sfr_wr;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Peripheral model: each register reads as its address xor 0x5A.
  assign f_sfr_rdata = f_sfr_addr ^ 8'h5A;
  assign h_sfr_rdata = h_sfr_addr ^ 8'h5A;

  idata_space_decoder #(.UPPER_RAM(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .acc_wr(acc_wr),
    .acc_indirect(acc_indirect), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .rd_data(f_rd_data), .rd_valid(f_rd_valid), .bad_access(f_bad),
    .sfr_sel(f_sel), .sfr_wr(f_sfr_wr), .sfr_addr(f_sfr_addr),
    .sfr_wdata(f_sfr_wdata), .sfr_rdata(f_sfr_rdata));

  idata_space_decoder #(.UPPER_RAM(1'b0)) uut_half (
    .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .acc_wr(acc_wr),
    .acc_indirect(acc_indirect), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .rd_data(h_rd_data), .rd_valid(h_rd_valid), .bad_access(h_bad),
    .sfr_sel(h_sel), .sfr_wr(h_sfr_wr), .sfr_addr(h_sfr_addr),
    .sfr_wdata(h_sfr_wdata), .sfr_rdata(h_sfr_rdata));

  // Values captured in the strobe cycle (c_) and the cycle after (n_).
  logic       c_f_sel, c_f_wr, c_h_sel, c_h_wr;
  logic [7:0] c_f_addr, c_f_wdata;
  logic [7:0] n_f_data, n_h_data;
  logic       n_f_valid, n_h_valid, n_f_bad, n_h_bad;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic rd, input logic wr, input logic ind,
                        input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    acc_rd = rd; acc_wr = wr; acc_indirect = ind; acc_addr = a; acc_wdata = d;
    #1;
    c_f_sel = f_sel; c_f_wr = f_sfr_wr; c_h_sel = h_sel; c_h_wr = h_sfr_wr;
    c_f_addr = f_sfr_addr; c_f_wdata = f_sfr_wdata;
    @(negedge clk);
    acc_rd = 1'b0; acc_wr = 1'b0;
    n_f_data = f_rd_data; n_h_data = h_rd_data;
    n_f_valid = f_rd_valid; n_h_valid = h_rd_valid;
    n_f_bad = f_bad; n_h_bad = h_bad;
  endtask

  task automatic t_reset;
    check("R9 rd_valid full", {7'd0, f_rd_valid}, 8'd0);
    check("R9 bad full", {7'd0, f_bad}, 8'd0);
    check("R9 rd_valid half", {7'd0, h_rd_valid}, 8'd0);
    check("R9 bad half", {7'd0, h_bad}, 8'd0);
  endtask

  task automatic t_lower_shared;
    access(0, 1, 0, 8'h12, 8'hA5);
    check("R2 no valid after write", {7'd0, n_f_valid}, 8'd0);
    access(1, 0, 1, 8'h12, 8'h00);
    check("R1 direct->indirect full", n_f_data, 8'hA5);
    check("R1 direct->indirect half", n_h_data, 8'hA5);
    check("R2 valid after read", {7'd0, n_f_valid}, 8'd1);
    access(0, 1, 1, 8'h7F, 8'h3C);
    access(1, 0, 0, 8'h7F, 8'h00);
    check("R1 indirect->direct full", n_f_data, 8'h3C);
    check("R1 indirect->direct half", n_h_data, 8'h3C);
    check("R5 no sel low addr", {7'd0, c_f_sel}, 8'd0);
  endtask

  task automatic t_sfr_port;
    access(0, 1, 0, 8'h90, 8'h77);
    check("R3 sel", {7'd0, c_f_sel}, 8'd1);
    check("R3 wr", {7'd0, c_f_wr}, 8'd1);
    check("R3 addr", c_f_addr, 8'h90);
    check("R3 wdata", c_f_wdata, 8'h77);
    check("R3 sel half", {7'd0, c_h_sel}, 8'd1);
    access(1, 0, 0, 8'hA0, 8'h00);
    check("R3 wr low on read", {7'd0, c_f_wr}, 8'd0);
    check("R4 sfr read full", n_f_data, 8'hA0 ^ 8'h5A);
    check("R4 sfr read half", n_h_data, 8'hA0 ^ 8'h5A);
    access(1, 1, 1, 8'h90, 8'h00);
    check("R5 indirect no sel full", {7'd0, c_f_sel}, 8'd0);
    check("R5 indirect no sfr_wr half", {7'd0, c_h_wr}, 8'd0);
  endtask

  task automatic t_upper_ram;
    access(0, 1, 0, 8'h05, 8'h11);
    access(0, 1, 1, 8'h85, 8'hC3);
    check("R6 no bad on write", {7'd0, n_f_bad}, 8'd0);
    check("R8 bad on hole write", {7'd0, n_h_bad}, 8'd1);
    check("R8 no sel on hole write", {7'd0, c_h_sel}, 8'd0);
    access(1, 0, 1, 8'h85, 8'h00);
    check("R6 upper read", n_f_data, 8'hC3);
    check("R6 no bad on read", {7'd0, n_f_bad}, 8'd0);
    check("R7 hole read data", n_h_data, 8'hFF);
    check("R7 hole read bad", {7'd0, n_h_bad}, 8'd1);
    access(1, 0, 0, 8'h05, 8'h00);
    check("R6 lower separate", n_f_data, 8'h11);
    check("R8 lower untouched", n_h_data, 8'h11);
    check("R7 bad clears", {7'd0, n_h_bad}, 8'd0);
    access(0, 1, 0, 8'h85, 8'hEE);
    access(1, 0, 1, 8'h85, 8'h00);
    check("R11 upper kept", n_f_data, 8'hC3);
  endtask

  task automatic t_same_cycle;
    access(0, 1, 0, 8'h20, 8'h01);
    access(1, 1, 0, 8'h20, 8'h02);
    check("R10 old value full", n_f_data, 8'h01);
    check("R10 old value half", n_h_data, 8'h01);
    access(1, 0, 1, 8'h20, 8'h00);
    check("R10 new stored", n_f_data, 8'h02);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_lower_shared;
    t_sfr_port;
    t_upper_ram;
    t_same_cycle;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule